// File: doc/BRIEF.md
# Nine-Bit UART With Address Filtering

This block is an asynchronous serial transmitter and receiver for point-to-multipoint links. It sends and receives either a short frame (start bit, eight data bits, stop bit) or a long frame that puts a ninth data bit between the data byte and the stop bit. On a shared bus the ninth bit marks address bytes. With the filter enabled, a receiver raises its receive flag only for address frames. In short-frame mode the filter instead rejects frames whose stop bit is wrong.

A free-running baud tick at sixteen times the bit rate drives both directions. The receiver votes on three samples around the middle of each bit and discards a start bit that has gone high again by mid-bit. A sticky framing-error flag records any frame whose stop bit sampled low. A selector chooses whether the top control bit shows that flag or the upper mode bit. The transmit, receive and framing-error flags each stay set until their own clear input is pulsed.

Top module: `uart9_core`

## Requirements
- R1: After reset, txd_o and the top control bit follow the idle state: txd_o is 1, tx_busy_o is 0, all three flags are 0, rx_data_o is 0 and rx_bit9_o is 0.
- R2: Mode encoding is 2'b01 for the short frame and 2'b10 or 2'b11 for the long frame (mode_i[1] set). A transmit frame starts on the clock after tx_load_i while idle. It sends a low start bit, the data LSB first, tx_bit9_i only in long mode, then a high stop bit. Each bit lasts 16 baud ticks. tx_load_i while busy is ignored, and txd_o is 1 whenever the transmitter is idle.
- R3: tx_flag_o rises on the same clock that txd_o enters the stop bit. It stays set until tx_flag_clr_i is pulsed.
- R4: Each received bit is the majority of the samples taken at oversample ticks 8, 9 and 10 of the bit. A one-tick glitch at tick 9 does not change the received byte.
- R5: A start bit that samples high at mid-bit is dropped without setting any flag, and the receiver is ready for the next frame.
- R6: In long mode with filter_en_i at 1, a frame whose ninth bit is 0 sets no receive flag and leaves rx_data_o unchanged. A frame whose ninth bit is 1 is accepted. With filter_en_i at 0 every frame is accepted and the ninth bit appears on rx_bit9_o.
- R7: In short mode with filter_en_i at 1, a frame with a low stop bit is not accepted. With filter_en_i at 0 it is accepted, and the sampled stop bit is written to rx_bit9_o.
- R8: A stop bit sampled low sets fe_flag_o whether or not the frame is accepted. fe_flag_o stays set until fe_flag_clr_i is pulsed.
- R9: ctrl_top_o shows fe_flag_o when fe_sel_i is 1, and mode_i[1] when fe_sel_i is 0.
- R10: With rx_en_i at 0, a complete frame on rxd_i leaves all receive outputs and flags unchanged.
- R11: rx_flag_o rises on the tenth baud tick of the stop bit, counting the tick after the line settles as tick 1. It stays set until rx_flag_clr_i is pulsed.
- R12: rx_data_o and rx_bit9_o change only on an accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| mode_i | input | 2 | Frame mode; bit 1 selects the long frame |
| filter_en_i | input | 1 | Multiprocessor receive filter enable |
| fe_sel_i | input | 1 | Top control bit shows the framing error when 1 |
| tx_load_i | input | 1 | Start a transmit frame |
| tx_data_i | input | 8 | Transmit byte |
| tx_bit9_i | input | 1 | Transmit ninth bit |
| txd_o | output | 1 | Serial output |
| tx_busy_o | output | 1 | Transmitter active |
| rx_en_i | input | 1 | Receiver enable |
| rxd_i | input | 1 | Serial input, asynchronous |
| rx_data_o | output | 8 | Last accepted byte |
| rx_bit9_o | output | 1 | Last accepted ninth or stop bit |
| tx_flag_o | output | 1 | Transmit interrupt flag |
| rx_flag_o | output | 1 | Receive interrupt flag |
| fe_flag_o | output | 1 | Framing-error flag |
| ctrl_top_o | output | 1 | Top control bit view |
| tx_flag_clr_i | input | 1 | Clear transmit flag |
| rx_flag_clr_i | input | 1 | Clear receive flag |
| fe_flag_clr_i | input | 1 | Clear framing-error flag |

## Verification
The bench drives filtered frames in both frame lengths: an address frame, a data frame and a frame with a bad stop bit. A design that mixed up the two filter rules would either drop valid data or pass frames that should be filtered, and the unchanged rx_data_o after a rejected frame exposes both faults. It also checks that the receive flag rises on the exact tick at mid-stop, so an off-by-one sample counter shows up even when the data comes out right. Two further cases target the sampling logic. A one-tick glitch inside a data bit catches single-sample decoding, and a short low pulse on an idle line catches a receiver that commits to a false start and then swallows the next frame. Transmit line and flag are compared with a tick-counting model on every clock, which catches a late flag or a load accepted mid-frame.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              nine_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit9_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              stop_start_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);

  logic [DATA_W+1:0] frame_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q, last_q, idx_nxt;
  logic              txd_q, busy_q, bound;

  assign idx_nxt = idx_q + 1'b1;
  assign bound   = busy_q & tick_i & (cnt_q == CNT_LAST);
  assign stop_start_o = bound & (idx_nxt == last_q);
  assign txd_o  = txd_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      txd_q   <= 1'b1;
      busy_q  <= 1'b0;
    end else if (!busy_q) begin
      if (load_i) begin
        frame_q <= {1'b1, (nine_i ? bit9_i : 1'b1), data_i};
        last_q  <= nine_i ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
        cnt_q   <= '0;
        idx_q   <= '0;
        txd_q   <= 1'b0;
        busy_q  <= 1'b1;
      end
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
          txd_q  <= 1'b1;
        end else begin
          idx_q   <= idx_nxt;
          txd_q   <= frame_q[0];
          frame_q <= {1'b1, frame_q[DATA_W+1:1]};
        end
      end
    end
  end
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int SYNC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              nine_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic              stop_ok_o,
  output logic              nine_frame_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ninth_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 3);
  localparam int MID   = OVS / 2;
  localparam logic [CNT_W-1:0] C_S0   = CNT_W'(MID - 2);
  localparam logic [CNT_W-1:0] C_S1   = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] C_MID  = CNT_W'(MID);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(OVS - 1);

  logic [SYNC-1:0]   sync_q;
  logic              rx_s, s_a_q, s_b_q, bit_v, active_q, nine_q, ninth_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q, last_idx;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC-2:0], rxd_i};
  end
  assign rx_s = sync_q[SYNC-1];

  assign bit_v    = maj3(s_a_q, s_b_q, rx_s);
  assign last_idx = nine_q ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
  assign done_o   = active_q & tick_i & (cnt_q == C_MID) & (idx_q == last_idx);
  assign stop_ok_o    = bit_v;
  assign nine_frame_o = nine_q;
  assign data_o       = sh_q;
  assign ninth_o      = nine_q ? ninth_q : bit_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
      s_a_q    <= 1'b1;
      s_b_q    <= 1'b1;
      nine_q   <= 1'b0;
      ninth_q  <= 1'b0;
      sh_q     <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
    end else if (!active_q) begin
      if (tick_i && !rx_s) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        idx_q    <= '0;
        nine_q   <= nine_i;
      end
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == C_S0) s_a_q <= rx_s;
      if (cnt_q == C_S1) s_b_q <= rx_s;
      if (cnt_q == C_MID) begin
        if (idx_q == '0) begin
          if (bit_v) active_q <= 1'b0;  // false start
        end else if (idx_q <= IDX_W'(DATA_W)) begin
          sh_q <= {bit_v, sh_q[DATA_W-1:1]};
        end else if (nine_q && idx_q == IDX_W'(DATA_W + 1)) begin
          ninth_q <= bit_v;
        end
        if (idx_q == last_idx) active_q <= 1'b0;
      end
      if (cnt_q == C_LAST) idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart9_core.sv
module uart9_core #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int SYNC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic [1:0]        mode_i,
  input  logic              filter_en_i,
  input  logic              fe_sel_i,
  input  logic              tx_load_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_bit9_i,
  output logic              txd_o,
  output logic              tx_busy_o,
  input  logic              rx_en_i,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o,
  output logic              tx_flag_o,
  output logic              rx_flag_o,
  output logic              fe_flag_o,
  output logic              ctrl_top_o,
  input  logic              tx_flag_clr_i,
  input  logic              rx_flag_clr_i,
  input  logic              fe_flag_clr_i
);
  logic              tx_stop, rx_done, rx_stop_ok, rx_nine, rx_ninth, accept;
  logic [DATA_W-1:0] rx_byte;

  uart9_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk_i, .rst_ni, .tick_i(baud_tick_i), .nine_i(mode_i[1]),
    .load_i(tx_load_i), .data_i(tx_data_i), .bit9_i(tx_bit9_i),
    .txd_o, .busy_o(tx_busy_o), .stop_start_o(tx_stop)
  );

  uart9_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC(SYNC)) u_rx (
    .clk_i, .rst_ni, .tick_i(baud_tick_i), .en_i(rx_en_i), .nine_i(mode_i[1]),
    .rxd_i, .done_o(rx_done), .stop_ok_o(rx_stop_ok), .nine_frame_o(rx_nine),
    .data_o(rx_byte), .ninth_o(rx_ninth)
  );

  // filter: long frames need an address bit, short frames a good stop bit
  assign accept = rx_done & (!filter_en_i | (rx_nine ? rx_ninth : rx_stop_ok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_flag_o <= 1'b0;
      rx_flag_o <= 1'b0;
      fe_flag_o <= 1'b0;
      rx_data_o <= '0;
      rx_bit9_o <= 1'b0;
    end else begin
      if (tx_stop)            tx_flag_o <= 1'b1;
      else if (tx_flag_clr_i) tx_flag_o <= 1'b0;
      if (accept)             rx_flag_o <= 1'b1;
      else if (rx_flag_clr_i) rx_flag_o <= 1'b0;
      if (rx_done && !rx_stop_ok) fe_flag_o <= 1'b1;
      else if (fe_flag_clr_i)     fe_flag_o <= 1'b0;
      if (accept) begin
        rx_data_o <= rx_byte;
        rx_bit9_o <= rx_ninth;
      end
    end
  end

  assign ctrl_top_o = fe_sel_i ? fe_flag_o : mode_i[1];
endmodule

// File: rtl/uart9_core_chk.sv
module uart9_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              txd_o,
  input logic              tx_busy_o,
  input logic              tx_flag_o,
  input logic              tx_flag_clr_i,
  input logic              rx_flag_o,
  input logic              rx_flag_clr_i,
  input logic              fe_flag_o,
  input logic              fe_flag_clr_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_bit9_o
);
  AST_TX_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_o |-> txd_o);  // R2
  AST_TX_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy_o) |-> !txd_o);  // R2
  AST_TX_FLAG_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_flag_o) |-> (txd_o && tx_busy_o));  // R3
  AST_TX_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_flag_o && !tx_flag_clr_i) |=> tx_flag_o);  // R3
  AST_FE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_flag_o && !fe_flag_clr_i) |=> fe_flag_o);  // R8
  AST_RX_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_flag_o && !rx_flag_clr_i) |=> rx_flag_o);  // R11
  AST_RX_DATA_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(rx_data_o) && $stable(rx_bit9_o)) |-> rx_flag_o);  // R12
endmodule

bind uart9_core uart9_core_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .txd_o(txd_o), .tx_busy_o(tx_busy_o),
  .tx_flag_o(tx_flag_o), .tx_flag_clr_i(tx_flag_clr_i),
  .rx_flag_o(rx_flag_o), .rx_flag_clr_i(rx_flag_clr_i),
  .fe_flag_o(fe_flag_o), .fe_flag_clr_i(fe_flag_clr_i),
  .rx_data_o(rx_data_o), .rx_bit9_o(rx_bit9_o)
);

// File: tb/uart9_core_tb_top.sv
`timescale 1ns/1ps
module uart9_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [1:0] mode = 2'b01;
  logic filt = 1'b0, fe_sel = 1'b0;
  logic tx_load = 1'b0, tx_b9 = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic rx_en = 1'b0, rxd = 1'b1;
  logic tx_clr = 1'b0, rx_clr = 1'b0, fe_clr = 1'b0;
  logic txd, busy, rx_b9, tx_flag, rx_flag, fe_flag, ctop;
  logic [7:0] rx_data;

  int n_cmp = 0, n_err = 0, tcnt = 0;

  always #2 clk = ~clk;

  uart9_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .mode_i(mode),
    .filter_en_i(filt), .fe_sel_i(fe_sel), .tx_load_i(tx_load),
    .tx_data_i(tx_data), .tx_bit9_i(tx_b9), .txd_o(txd), .tx_busy_o(busy),
    .rx_en_i(rx_en), .rxd_i(rxd), .rx_data_o(rx_data), .rx_bit9_o(rx_b9),
    .tx_flag_o(tx_flag), .rx_flag_o(rx_flag), .fe_flag_o(fe_flag),
    .ctrl_top_o(ctop), .tx_flag_clr_i(tx_clr), .rx_flag_clr_i(rx_clr),
    .fe_flag_clr_i(fe_clr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // baud tick every 4 clocks
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    tick = (tcnt == 0);
  end

  // transmit reference model
  logic m_txd = 1'b1, m_flag = 1'b0, m_busy = 1'b0, m_set;
  int   m_ticks = 0;
  bit   m_q[$];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_txd = 1'b1; m_flag = 1'b0; m_busy = 1'b0; m_q.delete();
    end else begin
      m_set = 1'b0;
      if (!m_busy && tx_load) begin
        m_q.delete();
        for (int i = 0; i < 8; i++) m_q.push_back(tx_data[i]);
        if (mode[1]) m_q.push_back(tx_b9);
        m_q.push_back(1'b1);
        m_txd = 1'b0; m_busy = 1'b1; m_ticks = 0;
      end else if (m_busy && tick) begin
        m_ticks++;
        if (m_ticks == 16) begin
          m_ticks = 0;
          if (m_q.size() == 0) begin
            m_busy = 1'b0; m_txd = 1'b1;
          end else begin
            m_txd = m_q.pop_front();
            if (m_q.size() == 0) m_set = 1'b1;
          end
        end
      end
      if (m_set) m_flag = 1'b1;
      else if (tx_clr) m_flag = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 txd", txd, m_txd);
      check("R2 busy", busy, m_busy);
      check("R3 tx_flag", tx_flag, m_flag);
    end
  end

  task automatic wait_tick();
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); tx_clr = 1; rx_clr = 1; fe_clr = 1;
    @(negedge clk); tx_clr = 0; rx_clr = 0; fe_clr = 0;
  endtask

  task automatic send_tx(input logic [7:0] d, input logic b9, input logic poke);
    @(negedge clk); tx_data = d; tx_b9 = b9; tx_load = 1;
    @(negedge clk); tx_load = 0;
    if (poke) begin
      repeat (100) @(negedge clk);
      tx_data = 8'hFF; tx_b9 = ~b9; tx_load = 1;  // ignored while busy
      @(negedge clk); tx_load = 0;
    end
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // glitch_bit: frame bit index to disturb at tick 9, -1 for none
  task automatic rx_frame(input logic [7:0] d, input logic has9, input logic b9,
                          input logic stop, input int glitch_bit, input bit tchk);
    logic bits[$];
    bits.push_back(1'b0);
    for (int i = 0; i < 8; i++) bits.push_back(d[i]);
    if (has9) bits.push_back(b9);
    bits.push_back(stop);
    wait_tick();
    foreach (bits[k]) begin
      rxd = bits[k];
      if (k == glitch_bit) begin
        repeat (8) wait_tick();
        rxd = ~bits[k];
        wait_tick();
        rxd = bits[k];
        repeat (7) wait_tick();
      end else if (tchk && k == bits.size() - 1) begin
        repeat (9) wait_tick();
        check("R11 rx_flag before mid-stop", rx_flag, 1'b0);
        wait_tick();
        check("R11 rx_flag at mid-stop", rx_flag, 1'b1);
        repeat (6) wait_tick();
      end else begin
        repeat (16) wait_tick();
      end
    end
    rxd = 1'b1;
    repeat (4) wait_tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 txd", txd, 1'b1);
    check("R1 busy", busy, 1'b0);
    check("R1 flags", {tx_flag, rx_flag, fe_flag}, 3'b000);
    check("R1 rx_data", rx_data, 8'h00);
    check("R1 rx_bit9", rx_b9, 1'b0);
    check("R9 ctrl_top mode view", ctop, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // transmit
    mode = 2'b01; send_tx(8'hA5, 1'b1, 1'b0);
    check("R3 tx_flag after short frame", tx_flag, 1'b1);
    repeat (50) @(negedge clk);
    check("R3 tx_flag held", tx_flag, 1'b1);
    pulse_clr();
    check("R3 tx_flag cleared", tx_flag, 1'b0);
    mode = 2'b11; send_tx(8'h3C, 1'b1, 1'b1);
    pulse_clr();
    mode = 2'b10; send_tx(8'h81, 1'b0, 1'b1);
    pulse_clr();

    // receive, short frame
    rx_en = 1; mode = 2'b01; filt = 0;
    rx_frame(8'h5A, 0, 0, 1'b1, -1, 0);
    check("R4 short rx data", rx_data, 8'h5A);
    check("R7 stop bit in bit9", rx_b9, 1'b1);
    check("R11 rx_flag set", rx_flag, 1'b1);
    check("R8 no framing error", fe_flag, 1'b0);
    repeat (60) @(negedge clk);
    check("R11 rx_flag held", rx_flag, 1'b1);
    pulse_clr();

    rx_frame(8'hC6, 0, 0, 1'b0, -1, 0);
    check("R7 bad stop accepted unfiltered", rx_flag, 1'b1);
    check("R7 bad stop stored", rx_b9, 1'b0);
    check("R7 data", rx_data, 8'hC6);
    check("R8 fe set", fe_flag, 1'b1);
    @(negedge clk); rx_clr = 1; @(negedge clk); rx_clr = 0;
    repeat (40) @(negedge clk);
    check("R8 fe held", fe_flag, 1'b1);
    fe_sel = 1; @(negedge clk);
    check("R9 ctrl_top fe view", ctop, 1'b1);
    fe_sel = 0; @(negedge clk);
    check("R9 ctrl_top short mode", ctop, 1'b0);
    mode = 2'b11; @(negedge clk);
    check("R9 ctrl_top long mode", ctop, 1'b1);
    mode = 2'b01;
    pulse_clr();
    check("R8 fe cleared", fe_flag, 1'b0);

    filt = 1;
    rx_frame(8'h33, 0, 0, 1'b0, -1, 0);
    check("R7 filtered bad stop no flag", rx_flag, 1'b0);
    check("R12 data kept", rx_data, 8'hC6);
    check("R8 fe on filtered frame", fe_flag, 1'b1);
    pulse_clr();

    // receive, long frame
    mode = 2'b11;
    rx_frame(8'h77, 1, 1'b0, 1'b1, -1, 0);
    check("R6 data frame filtered", rx_flag, 1'b0);
    check("R6 data kept", rx_data, 8'hC6);
    rx_frame(8'hC3, 1, 1'b1, 1'b1, -1, 1);
    check("R6 address frame data", rx_data, 8'hC3);
    check("R6 address frame bit9", rx_b9, 1'b1);
    pulse_clr();
    mode = 2'b10; filt = 0;
    rx_frame(8'h0F, 1, 1'b0, 1'b1, -1, 0);
    check("R6 unfiltered flag", rx_flag, 1'b1);
    check("R6 unfiltered data", rx_data, 8'h0F);
    check("R6 unfiltered bit9", rx_b9, 1'b0);
    pulse_clr();

    // glitch and false start
    mode = 2'b01;
    rx_frame(8'h00, 0, 0, 1'b1, 4, 0);
    check("R4 glitch rejected", rx_data, 8'h00);
    check("R4 glitch frame flag", rx_flag, 1'b1);
    pulse_clr();
    wait_tick(); rxd = 0;
    repeat (4) wait_tick(); rxd = 1;
    repeat (40) wait_tick();
    check("R5 false start no flag", rx_flag, 1'b0);
    check("R5 false start no fe", fe_flag, 1'b0);
    rx_frame(8'h96, 0, 0, 1'b1, -1, 0);
    check("R5 recovers", rx_data, 8'h96);
    pulse_clr();

    // disabled receiver
    rx_en = 0;
    rx_frame(8'h11, 0, 0, 1'b0, -1, 0);
    check("R10 disabled flag", rx_flag, 1'b0);
    check("R10 disabled fe", fe_flag, 1'b0);
    check("R10 disabled data", rx_data, 8'h96);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule